// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block stores the settings of a set of memory protection entries: one configuration byte and one address register per entry, plus a small security control register. Software reaches all of them through a single register read/write port that selects a register kind and an index. Configuration bytes are packed several to a register. The address registers are one per index. Every write passes through lock rules before it can change anything.

The raw contents of every byte and address register, and the three security bits, are driven straight out of the block. A range decoder and an access checker, placed next to the bank, use them. A one-cycle `modified` pulse tells those neighbours that a stored value really changed, so they can drop any cached decisions. The entry count, the register width and the availability of the enhanced security mode are parameters.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After reset every configuration byte, address register and security bit is zero, `modified` is low, and every read returns zero.
- R2: A configuration register with index n holds one byte per entry, least significant byte first: byte j belongs to entry 4n+j, and a register has XLEN/8 bytes. Byte layout: bit 7 = lock, bits [4:3] = match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 2 = X, bit 1 = W, bit 0 = R. Bytes of entries that do not exist read as zero.
- R3: Without the enhanced mode, a write to the configuration byte or to the address register of an entry whose lock bit is set has no effect.
- R4: A write to address register i has no effect when entry i+1 exists, has its lock bit set and has match mode 1 (top-of-range).
- R5: In the enhanced mode, with the bypass bit set, a configuration byte can be written even when it is locked. With bypass and lockdown clear, only unlocked bytes can be written.
- R6: In the enhanced mode with lockdown set and bypass clear, a new configuration byte is stored only if it has lock set and X clear, or if it has lock clear and its X/W/R bits are not exactly 3'b110.
- R7: The bypass bit cannot go from 0 to 1 while any entry has its lock bit set. Clearing it is always allowed.
- R8: The security register has lockdown at bit 0, whitelist at bit 1 and bypass at bit 2. In the enhanced mode, lockdown and whitelist stay set once set. Without the enhanced mode, all three bits stay zero.
- R9: A register kind code of 3, or an address or configuration index beyond the implemented entries, is ignored on write and reads as zero. Kind codes: 0 configuration, 1 address, 2 security.
- R10: `modified` is high for exactly the one cycle after a write that changed at least one stored bit. It stays low after a write that changes nothing.
- R11: `cfg_bytes[8e+7:8e]` and `addr_regs[XLEN*e+XLEN-1:XLEN*e]` always show the stored values of entry e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_kind | input | 2 | Register kind: 0 config, 1 address, 2 security, 3 none |
| csr_idx | input | $clog2(NUM_ENTRIES)+1 | Register index within the kind |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register (combinational) |
| modified | output | 1 | One-cycle pulse after any stored value changed |
| cfg_bytes | output | 8*NUM_ENTRIES | All configuration bytes, entry 0 lowest |
| addr_regs | output | XLEN*NUM_ENTRIES | All address registers, entry 0 lowest |
| sec_lockdown | output | 1 | Security lockdown bit |
| sec_whitelist | output | 1 | Security whitelist bit |
| sec_bypass | output | 1 | Security lock-bypass bit |

## Verification
The bench builds two copies with six entries and a 32-bit register width: one with the enhanced mode and one without. So both lock policies run against the same stimulus. Six entries leave the second configuration register half empty and the index field covers up to 15. This makes unimplemented bytes and out-of-range indices easy to reach. Under lockdown, all 256 byte values are written to the top entries, which covers the full acceptance table of R6.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csr_kind_e;

  localparam int CFG_LOCK_BIT = 7;
  localparam int CFG_X_BIT    = 2;
  localparam logic [1:0] MODE_TOR = 2'b01;
  localparam logic [2:0] RWX_SHARED = 3'b110;

  localparam int SEC_LD = 0;
  localparam int SEC_WL = 1;
  localparam int SEC_BP = 2;

  function automatic logic is_locked_tor(input logic [7:0] b);
    return b[CFG_LOCK_BIT] && (b[4:3] == MODE_TOR);
  endfunction

endpackage

// File: rtl/pmp_cfg_slot.sv
module pmp_cfg_slot
  import pmp_bank_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wr_byte,
  input  logic       bypass,
  input  logic       lockdown,
  output logic [7:0] cfg_q,
  output logic       changed
);

  logic accept;
  logic wr_en;

  always_comb begin
    if (ENHANCED) begin
      accept = bypass
             | (!lockdown && !cfg_q[CFG_LOCK_BIT])
             | (lockdown && ((wr_byte[CFG_LOCK_BIT] && !wr_byte[CFG_X_BIT]) ||
                             (!wr_byte[CFG_LOCK_BIT] && (wr_byte[2:0] != RWX_SHARED))));
    end else begin
      accept = !cfg_q[CFG_LOCK_BIT];
    end
    wr_en   = wr_hit && accept && (wr_byte != cfg_q);
    changed = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_byte;
    end
  end

  AST_LOCKED_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cfg_q[CFG_LOCK_BIT] && !bypass && !lockdown) |=> $stable(cfg_q)); // R3

  AST_LOCKDOWN_REJECTS_LX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lockdown && !bypass && wr_byte[CFG_LOCK_BIT] && wr_byte[CFG_X_BIT])
      |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/pmp_addr_slot.sv
module pmp_addr_slot #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [XLEN-1:0] wr_data,
  input  logic            own_lock,
  input  logic            guard_lock,
  output logic [XLEN-1:0] addr_q,
  output logic            changed
);

  logic wr_en;

  always_comb begin
    wr_en   = wr_hit && !own_lock && !guard_lock && (wr_data != addr_q);
    changed = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_en) begin
      addr_q <= wr_data;
    end
  end

  AST_TOR_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && guard_lock) |=> $stable(addr_q)); // R4

  AST_LOCKED_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && own_lock) |=> $stable(addr_q)); // R3

endmodule

// File: rtl/pmp_seccfg_reg.sv
module pmp_seccfg_reg
  import pmp_bank_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wr_bits,
  input  logic       any_locked,
  output logic       lockdown_q,
  output logic       whitelist_q,
  output logic       bypass_q,
  output logic       changed
);

  logic [2:0] cur;
  logic [2:0] nxt;
  logic       wr_en;

  assign cur = {bypass_q, whitelist_q, lockdown_q};

  always_comb begin
    nxt = wr_bits;
    if (!bypass_q && any_locked) begin
      nxt[SEC_BP] = 1'b0;
    end
    if (ENHANCED) begin
      nxt[SEC_LD] = nxt[SEC_LD] | lockdown_q;
      nxt[SEC_WL] = nxt[SEC_WL] | whitelist_q;
    end else begin
      nxt = '0;
    end
    wr_en   = wr && (nxt != cur);
    changed = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockdown_q  <= 1'b0;
      whitelist_q <= 1'b0;
      bypass_q    <= 1'b0;
    end else if (wr_en) begin
      lockdown_q  <= nxt[SEC_LD];
      whitelist_q <= nxt[SEC_WL];
      bypass_q    <= nxt[SEC_BP];
    end
  end

  AST_BYPASS_RISE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_q) |-> $past(!any_locked)); // R7

  generate
    if (ENHANCED) begin : g_sticky
      AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown_q |=> lockdown_q); // R8
      AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        whitelist_q |=> whitelist_q); // R8
    end else begin : g_plain
      AST_PLAIN_SEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(lockdown_q || whitelist_q || bypass_q)); // R8
    end
  endgenerate

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter bit ENHANCED    = 1'b1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic [1:0]                  csr_kind,
  input  logic [IDX_W-1:0]            csr_idx,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic                        modified,
  output logic [8*NUM_ENTRIES-1:0]    cfg_bytes,
  output logic [XLEN*NUM_ENTRIES-1:0] addr_regs,
  output logic                        sec_lockdown,
  output logic                        sec_whitelist,
  output logic                        sec_bypass
);

  localparam int BPC   = XLEN / 8;
  localparam int GROUP = 4;

  csr_kind_e                kind;
  int                       base_i;
  int                       idx_i;
  logic [NUM_ENTRIES-1:0]   cfg_chg;
  logic [NUM_ENTRIES-1:0]   addr_chg;
  logic [NUM_ENTRIES-1:0]   lock_vec;
  logic                     sec_chg;
  logic                     modified_d;
  logic                     modified_q;

  always_comb begin
    kind   = csr_kind_e'(csr_kind);
    idx_i  = int'(csr_idx);
    base_i = idx_i * GROUP;
  end

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      int              sel;
      logic            in_csr;
      logic            cfg_hit;
      logic            addr_hit;
      logic            guard;
      logic [XLEN-1:0] shifted;

      always_comb begin
        sel      = e - base_i;
        in_csr   = (sel >= 0) && (sel < BPC);
        shifted  = csr_wdata >> (8 * (in_csr ? sel : 0));
        cfg_hit  = csr_we && (kind == KIND_CFG) && in_csr;
        addr_hit = csr_we && (kind == KIND_ADDR) && (idx_i == e);
      end

      if (e + 1 < NUM_ENTRIES) begin : g_next
        assign guard = is_locked_tor(cfg_bytes[8*(e+1) +: 8]);
      end else begin : g_top
        assign guard = 1'b0;
      end

      assign lock_vec[e] = cfg_bytes[8*e + CFG_LOCK_BIT];

      pmp_cfg_slot #(.ENHANCED(ENHANCED)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (cfg_hit),
        .wr_byte  (shifted[7:0]),
        .bypass   (sec_bypass),
        .lockdown (sec_lockdown),
        .cfg_q    (cfg_bytes[8*e +: 8]),
        .changed  (cfg_chg[e])
      );

      pmp_addr_slot #(.XLEN(XLEN)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (addr_hit),
        .wr_data    (csr_wdata),
        .own_lock   (lock_vec[e]),
        .guard_lock (guard),
        .addr_q     (addr_regs[XLEN*e +: XLEN]),
        .changed    (addr_chg[e])
      );
    end
  endgenerate

  pmp_seccfg_reg #(.ENHANCED(ENHANCED)) u_sec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (csr_we && (kind == KIND_SEC)),
    .wr_bits     (csr_wdata[2:0]),
    .any_locked  (|lock_vec),
    .lockdown_q  (sec_lockdown),
    .whitelist_q (sec_whitelist),
    .bypass_q    (sec_bypass),
    .changed     (sec_chg)
  );

  // Read path: combinational select of stored contents
  always_comb begin
    logic [8*NUM_ENTRIES-1:0]    cfg_sh;
    logic [XLEN*NUM_ENTRIES-1:0] addr_sh;
    csr_rdata = '0;
    cfg_sh    = '0;
    addr_sh   = '0;
    unique case (kind)
      KIND_CFG: begin
        for (int j = 0; j < BPC; j++) begin
          if (base_i + j < NUM_ENTRIES) begin
            cfg_sh = cfg_bytes >> (8 * (base_i + j));
            csr_rdata[8*j +: 8] = cfg_sh[7:0];
          end
        end
      end
      KIND_ADDR: begin
        if (idx_i < NUM_ENTRIES) begin
          addr_sh   = addr_regs >> (XLEN * idx_i);
          csr_rdata = addr_sh[XLEN-1:0];
        end
      end
      KIND_SEC: begin
        csr_rdata[SEC_LD] = sec_lockdown;
        csr_rdata[SEC_WL] = sec_whitelist;
        csr_rdata[SEC_BP] = sec_bypass;
      end
      default: csr_rdata = '0;
    endcase
  end

  assign modified_d = (|cfg_chg) | (|addr_chg) | sec_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modified_q <= 1'b0;
    end else begin
      modified_q <= modified_d;
    end
  end

  assign modified = modified_q;

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    modified |-> $past(csr_we)); // R10

  AST_OOR_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (kind == KIND_ADDR) && (idx_i >= NUM_ENTRIES)) |=> $stable(addr_regs)); // R9

  AST_NONE_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (kind == KIND_NONE)) |=> (!modified && $stable(cfg_bytes))); // R9

endmodule

// File: tb/pmp_cfg_bank_bench.sv
module pmp_cfg_bank_bench;

  localparam int N  = 6;
  localparam int XL = 32;

  logic        clk;
  logic        rst_n;
  logic        we_w   [2];
  logic [1:0]  kind;
  logic [3:0]  idx;
  logic [31:0] wdata;
  logic [31:0] rdata_w [2];
  logic        mod_w  [2];
  logic [47:0] cfg_w  [2];
  logic [191:0] addr_w [2];
  logic        ld_w [2];
  logic        wl_w [2];
  logic        bp_w [2];

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_cfg  [2][N];
  logic [31:0] m_addr [2][N];
  logic        m_ld [2];
  logic        m_wl [2];
  logic        m_bp [2];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(XL), .ENHANCED(1'b1)) u_pmp_cfg_bank (
    .clk(clk), .rst_n(rst_n), .csr_we(we_w[0]), .csr_kind(kind), .csr_idx(idx),
    .csr_wdata(wdata), .csr_rdata(rdata_w[0]), .modified(mod_w[0]),
    .cfg_bytes(cfg_w[0]), .addr_regs(addr_w[0]), .sec_lockdown(ld_w[0]),
    .sec_whitelist(wl_w[0]), .sec_bypass(bp_w[0]));

  pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(XL), .ENHANCED(1'b0)) u_pmp_cfg_bank_plain (
    .clk(clk), .rst_n(rst_n), .csr_we(we_w[1]), .csr_kind(kind), .csr_idx(idx),
    .csr_wdata(wdata), .csr_rdata(rdata_w[1]), .modified(mod_w[1]),
    .cfg_bytes(cfg_w[1]), .addr_regs(addr_w[1]), .sec_lockdown(ld_w[1]),
    .sec_whitelist(wl_w[1]), .sec_bypass(bp_w[1]));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic check(string tag, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(int inst, string tag);
    logic [47:0]  ec = '0;
    logic [191:0] ea = '0;
    for (int e = 0; e < N; e++) begin
      ec[8*e +: 8]  = m_cfg[inst][e];
      ea[32*e +: 32] = m_addr[inst][e];
    end
    check({tag, " cfg R11"}, {144'd0, cfg_w[inst]}, {144'd0, ec});
    check({tag, " addr R11"}, addr_w[inst], ea);
    check({tag, " sec R8"}, {189'd0, bp_w[inst], wl_w[inst], ld_w[inst]},
          {189'd0, m_bp[inst], m_wl[inst], m_ld[inst]});
  endtask

  function automatic logic any_lock(int inst);
    logic r = 1'b0;
    for (int e = 0; e < N; e++) r |= m_cfg[inst][e][7];
    return r;
  endfunction

  task automatic wr(int inst, int k, int ix, logic [31:0] d, string tag);
    logic chg = 1'b0;
    if (k == 0) begin
      for (int j = 0; j < 4; j++) begin
        int e = 4 * ix + j;
        if (e < N) begin
          logic [7:0] nv = d[8*j +: 8];
          logic [7:0] ov = m_cfg[inst][e];
          logic ok;
          if (inst == 0)
            ok = m_bp[0] || (!m_ld[0] && !ov[7]) ||
                 (m_ld[0] && ((nv[7] && !nv[2]) || (!nv[7] && nv[2:0] != 3'b110)));
          else
            ok = !ov[7];
          if (ok && nv != ov) begin
            m_cfg[inst][e] = nv;
            chg = 1'b1;
          end
        end
      end
    end else if (k == 1) begin
      if (ix < N) begin
        logic guard = 1'b0;
        if (ix + 1 < N)
          guard = m_cfg[inst][ix+1][7] && (m_cfg[inst][ix+1][4:3] == 2'b01);
        if (!guard && !m_cfg[inst][ix][7] && d != m_addr[inst][ix]) begin
          m_addr[inst][ix] = d;
          chg = 1'b1;
        end
      end
    end else if (k == 2) begin
      logic [2:0] v = d[2:0];
      if (!m_bp[inst] && any_lock(inst)) v[2] = 1'b0;
      if (inst == 0) begin
        v[0] = v[0] | m_ld[0];
        v[1] = v[1] | m_wl[0];
      end else begin
        v = 3'b000;
      end
      if (v != {m_bp[inst], m_wl[inst], m_ld[inst]}) chg = 1'b1;
      {m_bp[inst], m_wl[inst], m_ld[inst]} = v;
    end
    @(negedge clk);
    kind  = 2'(k);
    idx   = 4'(ix);
    wdata = d;
    we_w[inst] = 1'b1;
    @(negedge clk);
    we_w[inst] = 1'b0;
    kind = 2'd3;
    check({tag, " pulse R10"}, {191'd0, mod_w[inst]}, {191'd0, chg});
    check_state(inst, tag);
    @(negedge clk);
    check({tag, " pulse end R10"}, {191'd0, mod_w[inst]}, 192'd0);
  endtask

  task automatic rd(int inst, int k, int ix, string tag);
    logic [31:0] exp = '0;
    if (k == 0) begin
      for (int j = 0; j < 4; j++)
        if (4 * ix + j < N) exp[8*j +: 8] = m_cfg[inst][4*ix+j];
    end else if (k == 1) begin
      if (ix < N) exp = m_addr[inst][ix];
    end else if (k == 2) begin
      exp = {29'd0, m_bp[inst], m_wl[inst], m_ld[inst]};
    end
    kind = 2'(k);
    idx  = 4'(ix);
    #1;
    check({tag, " read"}, {160'd0, rdata_w[inst]}, {160'd0, exp});
  endtask

  initial begin
    rst_n = 1'b0;
    we_w[0] = 1'b0;
    we_w[1] = 1'b0;
    kind = 2'd3;
    idx = '0;
    wdata = '0;
    for (int i = 0; i < 2; i++) begin
      m_ld[i] = 1'b0; m_wl[i] = 1'b0; m_bp[i] = 1'b0;
      for (int e = 0; e < N; e++) begin
        m_cfg[i][e] = '0;
        m_addr[i][e] = '0;
      end
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("reset pulse R1", {191'd0, mod_w[i]}, 192'd0);
      check_state(i, "reset R1");
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 4; k++) rd(i, k, 0, "reset R1");

      for (int a = 0; a < 8; a++)
        wr(i, 1, a, 32'hA500_0000 ^ (a * 32'h0101_0101), a < N ? "addr R11" : "addr oor R9");
      for (int a = 0; a < 16; a++) rd(i, 1, a, "addr R9");

      wr(i, 0, 0, 32'h1B0A_1903, "cfg pack R2");
      wr(i, 0, 1, 32'h5544_0D0C, "cfg partial R2");
      wr(i, 0, 2, 32'h1111_1111, "cfg oor R9");
      for (int c = 0; c < 4; c++) rd(i, 0, c, "cfg R2");
      wr(i, 3, 0, 32'h7777_7777, "kind none R9");
      rd(i, 3, 0, "kind none R9");
      wr(i, 0, 0, 32'h1B0A_1903, "same value R10");
    end

    // plain instance: lock rules
    wr(1, 0, 0, 32'h1B88_1903, "lock tor R4");
    wr(1, 1, 1, 32'h0000_1234, "guarded addr R4");
    wr(1, 1, 2, 32'h0000_5678, "locked addr R3");
    wr(1, 0, 0, 32'h0000_0000, "locked cfg R3");
    wr(1, 1, 3, 32'h0000_9ABC, "unlocked tor addr R4");
    wr(1, 2, 0, 32'h0000_0007, "plain sec R8");
    rd(1, 2, 0, "plain sec R8");

    // enhanced instance: bypass, lockdown, sticky bits
    wr(0, 2, 0, 32'h0000_0004, "bypass set R7");
    wr(0, 0, 0, 32'h0000_0080, "lock e0 R5");
    wr(0, 0, 0, 32'h0000_0081, "bypass write R5");
    wr(0, 2, 0, 32'h0000_0000, "bypass clear R7");
    wr(0, 2, 0, 32'h0000_0004, "bypass blocked R7");
    wr(0, 0, 0, 32'h0303_0301, "locked skip R5");
    wr(0, 1, 0, 32'h0000_4444, "enh locked addr R3");
    wr(0, 2, 0, 32'h0000_0001, "lockdown set R8");
    wr(0, 2, 0, 32'h0000_0000, "lockdown sticky R8");
    wr(0, 2, 0, 32'h0000_0002, "whitelist set R8");
    wr(0, 2, 0, 32'h0000_0000, "both sticky R8");
    for (int v = 0; v < 256; v++)
      wr(0, 0, 1, {4{8'(v)}}, "lockdown sweep R6");
    for (int c = 0; c < 4; c++) rd(0, 0, c, "final cfg R2");
    rd(0, 2, 0, "final sec R8");

    summary();
    $finish;
  end

endmodule